// File: doc/BRIEF.md
# I2C Register-File Slave

This block lets a two-wire bus master reach a small register file through a fixed 7-bit slave address, `1000001`. The system clock oversamples SCL and SDA. Internal logic finds START, repeated START and STOP conditions, shifts bytes in and out MSB first, and pulls SDA low through an open-drain enable whenever it must acknowledge or send a zero.

An 8-bit word pointer selects the register. In a write transfer, the first byte after the address loads the pointer. Every later byte is written at the pointer, and the pointer then advances. In a read transfer, bytes come from the pointer, which advances after each byte. The pointer wraps from FFh to 00h and keeps its value across transfers.

The register file is outside the block. The block presents the pointer on `reg_addr`, expects the addressed byte on `reg_rdata` in the same cycle, and gives a one-cycle `reg_we` strobe together with `reg_wdata`.

States and transitions:
- A START in any state moves to ADDR. A STOP in any state moves to IDLE.
- ADDR: after eight bits, a matching address goes to ADDR_ACK and any other address goes to WAIT.
- ADDR_ACK: on the SCL fall that ends the acknowledge, a read goes to RD and a write goes to PTR.
- PTR goes to PTR_ACK after eight bits. PTR_ACK goes to WR.
- WR goes to WR_ACK after eight bits. WR_ACK goes back to WR.
- RD goes to RD_ACK after eight bits.
- RD_ACK goes to RD when the master acknowledges and to WAIT when it sends NACK.
- IDLE and WAIT leave only on START or STOP.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. From any state, including in the middle of a byte or as a repeated START, it begins a new address phase.
- R2: A rising SDA while SCL is high is a STOP. It returns the block to idle with SDA released. Bytes clocked after a STOP and before the next START get no acknowledge and cause no register write.
- R3: Only the address byte 82h (write) or 83h (read) is acknowledged, where the top seven bits equal `1000001` and bit 0 is the direction, 1 meaning read. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R4: The acknowledge is `sda_oe`=1 from the SCL fall after the eighth bit through the whole high period of the ninth clock. It is released after the ninth SCL fall.
- R5: In a write, the byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged and written once (`reg_we` pulses for one cycle) at the pointer, which then increments. There is no limit on the number of bytes.
- R6: In a read, bytes are sent MSB first starting at the current pointer. The pointer increments after every byte, and the next byte is loaded on the SCL fall that ends an acknowledged bit.
- R7: After the master answers a read byte with NACK, SDA stays released until the next START or STOP.
- R8: `sda_oe` changes only while the synchronised SCL is low. SDA is never driven high.
- R9: The pointer wraps from FFh to 00h and keeps its value across transfers, so a read without a pointer write continues where the previous transfer stopped.
- R10: After reset the block is idle with `sda_oe`=0 and `reg_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Word pointer, register select |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
A wrong state shows up on SDA within a single bus bit. A missing or misplaced acknowledge is seen by the master at the next ninth-clock high. A wrong transmit shift or pointer value shows up as a wrong data bit in the same read byte. A pointer that does not persist or wrap is only seen on the first byte of the next transfer, so the tests read back across transfer boundaries and across the FFh wrap. An FSM that misses a STOP or a mid-byte START is exposed at the next acknowledge slot, where an answer appears where none is expected, or the reverse.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000001,
    parameter int          PTR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 sda_s,
    input  logic [BYTE_BITS-1:0] reg_rdata,
    output logic [PTR_W-1:0]     reg_addr,
    output logic [BYTE_BITS-1:0] reg_wdata,
    output logic                 reg_we,
    output logic                 sda_oe,
    output slv_state_t           state
);
    localparam int          CNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    slv_state_t           nxt;
    logic [BYTE_BITS-1:0] rx_sr;
    logic [BYTE_BITS-1:0] tx_sr;
    logic [CNT_W-1:0]     bit_cnt;
    logic [PTR_W-1:0]     ptr;
    logic                 rw_q;
    logic                 mack_q;
    logic                 we_q;
    logic                 rx_done;
    logic                 tx_done;

    assign rx_done = scl_fall && (bit_cnt == CNT_FULL);
    assign tx_done = scl_fall && (bit_cnt == CNT_LAST);

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: nxt = state;
                ST_ADDR:     if (rx_done) nxt = (rx_sr[BYTE_BITS-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_RD : ST_PTR;
                ST_PTR:      if (rx_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) nxt = ST_WR;
                ST_WR:       if (rx_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR;
                ST_RD:       if (tx_done) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mack_q ? ST_RD : ST_WAIT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift registers, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            tx_sr   <= '1;
            bit_cnt <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                tx_sr   <= '1;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[BYTE_BITS-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (rx_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) rw_q <= rx_sr[0];
                            if (state == ST_PTR)  ptr  <= PTR_W'(rx_sr);
                            if (state == ST_WR)   we_q <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) tx_sr <= reg_rdata;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) ptr <= ptr + 1'b1;
                    end
                    ST_RD: begin
                        if (tx_done) begin
                            bit_cnt <= '0;
                            tx_sr   <= '1;
                            ptr     <= ptr + 1'b1;
                        end else if (scl_fall) begin
                            tx_sr   <= {tx_sr[BYTE_BITS-2:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall && mack_q) tx_sr <= reg_rdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        reg_addr  = ptr;
        reg_wdata = rx_sr;
        reg_we    = we_q;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                              sda_oe = ~tx_sr[BYTE_BITS-1];
            default:                            sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1000001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    slv_state_t state;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
    );

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_slv_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(8)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .reg_rdata(reg_rdata), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .sda_oe(sda_oe), .state(state)
    );
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk
    import i2c_slv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input slv_state_t state,
    input logic [7:0] reg_addr,
    input logic       sda_oe,
    input logic       reg_we
);
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != $past(reg_addr)) |->
            (reg_addr == $past(reg_addr) + 8'd1 || $past(state) == ST_PTR));

    assert_nack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .state(state),
    .reg_addr(reg_addr), .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic [7:0] mem [256];
    wire        sda_line = sda_m & ~sda_oe;
    int         checks = 0;
    int         fails = 0;
    int         wr_count = 0;
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    i2c_regfile_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // R8: output enable may only move while SCL is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) begin
            fails++;
            $display("FAIL R8 sda_oe changed with SCL high act=%0b exp=%0b", sda_oe, oe_prev);
        end
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] init_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            d = {d[6:0], sda_line};
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R10 reg_we after reset", reg_we, 0);
        chk(reg_addr == 8'h00, "R10 pointer after reset", reg_addr, 0);
    endtask

    task automatic t_write_basic();
        bit ack;
        bus_start();
        put_byte(8'h82, ack); chk(ack, "R3 ack on 82h", ack, 1);
        put_byte(8'h10, ack); chk(ack, "R4 ack on pointer byte", ack, 1);
        put_byte(8'hA5, ack); chk(ack, "R5 ack data 0", ack, 1);
        put_byte(8'h3C, ack); chk(ack, "R5 ack data 1", ack, 1);
        put_byte(8'hF0, ack); chk(ack, "R5 ack data 2", ack, 1);
        bus_stop();
        chk(mem[8'h10] == 8'hA5, "R5 mem[10]", mem[8'h10], 8'hA5);
        chk(mem[8'h11] == 8'h3C, "R5 mem[11]", mem[8'h11], 8'h3C);
        chk(mem[8'h12] == 8'hF0, "R5 mem[12]", mem[8'h12], 8'hF0);
        chk(mem[8'h13] == init_val(8'h13), "R5 mem[13] untouched", mem[8'h13], init_val(8'h13));
        chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
    endtask

    task automatic t_read_repeated();
        bit ack;
        logic [7:0] d;
        bus_start();
        put_byte(8'h82, ack);
        put_byte(8'h10, ack);
        bus_start();
        put_byte(8'h83, ack); chk(ack, "R1 ack 83h after repeated start", ack, 1);
        get_byte(1'b0, d); chk(d == 8'hA5, "R6 read byte 0", d, 8'hA5);
        get_byte(1'b0, d); chk(d == 8'h3C, "R6 read byte 1", d, 8'h3C);
        get_byte(1'b1, d); chk(d == 8'hF0, "R6 read byte 2", d, 8'hF0);
        get_byte(1'b1, d); chk(d == 8'hFF, "R7 released after NACK", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_read_persist();
        bit ack;
        logic [7:0] d;
        bus_start();
        put_byte(8'h83, ack); chk(ack, "R3 ack on 83h", ack, 1);
        get_byte(1'b1, d); chk(d == init_val(8'h13), "R9 pointer kept across transfers", d, init_val(8'h13));
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        bit ack;
        int wc;
        wc = wr_count;
        bus_start();
        put_byte(8'h84, ack); chk(!ack, "R3 no ack on 84h", ack, 0);
        put_byte(8'h55, ack); chk(!ack, "R3 rest ignored", ack, 0);
        bus_stop();
        bus_start();
        put_byte(8'h03, ack); chk(!ack, "R3 no ack on 03h", ack, 0);
        bus_stop();
        chk(wr_count == wc, "R3 no writes", wr_count, wc);
    endtask

    task automatic t_stop_ignore();
        bit ack;
        int wc;
        bus_start();
        put_byte(8'h82, ack);
        put_byte(8'h40, ack);
        bus_stop();
        wc = wr_count;
        put_byte(8'h82, ack); chk(!ack, "R2 no ack without start", ack, 0);
        put_byte(8'h66, ack); chk(!ack, "R2 data ignored", ack, 0);
        bus_stop();
        chk(wr_count == wc, "R2 no write after stop", wr_count, wc);
        chk(mem[8'h40] == init_val(8'h40), "R2 mem[40] unchanged", mem[8'h40], init_val(8'h40));
    endtask

    task automatic t_wrap();
        bit ack;
        logic [7:0] d;
        bus_start();
        put_byte(8'h82, ack);
        put_byte(8'hFE, ack);
        put_byte(8'h11, ack);
        put_byte(8'h22, ack);
        put_byte(8'h33, ack); chk(ack, "R5 ack across wrap", ack, 1);
        bus_stop();
        chk(mem[8'hFE] == 8'h11, "R9 mem[FE]", mem[8'hFE], 8'h11);
        chk(mem[8'hFF] == 8'h22, "R9 mem[FF]", mem[8'hFF], 8'h22);
        chk(mem[8'h00] == 8'h33, "R9 mem[00] after wrap", mem[8'h00], 8'h33);
        bus_start();
        put_byte(8'h82, ack);
        put_byte(8'hFF, ack);
        bus_start();
        put_byte(8'h83, ack);
        get_byte(1'b0, d); chk(d == 8'h22, "R9 read at FF", d, 8'h22);
        get_byte(1'b1, d); chk(d == 8'h33, "R9 read wraps to 00", d, 8'h33);
        bus_stop();
    endtask

    task automatic t_start_midbyte();
        bit ack;
        logic [7:0] d;
        bus_start();
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b0);
        bus_start();
        put_byte(8'h83, ack); chk(ack, "R1 start mid-byte restarts address", ack, 1);
        get_byte(1'b1, d); chk(d == init_val(8'h01), "R6 read at pointer 01", d, init_val(8'h01));
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write_basic();
        t_read_repeated();
        t_read_persist();
        t_wrong_addr();
        t_stop_ignore();
        t_wrap();
        t_start_midbyte();
        chk(1'b1, "R8 monitor", 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule